// File: doc/BRIEF.md
# Edge-Window Bit Error Monitor

This block estimates how often a recovered serial stream is in error by watching its data transitions. The sampler ahead of it reports, once per bit, whether a transition happened and whether that transition landed outside the expected timing window. Each misplaced transition counts as one error. Bits with no transition, and transitions inside the window, count as nothing. Errors are totalled over measurement intervals of a power-of-two number of bits. At the end of each interval the total is compared against a limit derived from a logarithmic threshold code.

The alarm output is active low. It drops when an interval's error count exceeds the limit. Once low, it returns high only after an interval whose count has fallen to half the limit or below. Counts in between leave it as it was. This hysteresis stops a marginal stream from toggling the alarm. A threshold code of zero turns the function off.

The code stands for a threshold level on a scale of one sixteenth per step, where log10(rate) = 4·level − 13. For each code, the block picks the interval length so that the limit count falls between 8 and 15. A lower threshold rate therefore gets a longer interval, and a coarse error fraction never has to be compared.

Top module: `edge_window_ber_monitor`

## Requirements
- R1: A bit adds one to the interval's error count only when `edge_seen` and `edge_late` are both 1 in that cycle. A late flag with no transition, or a transition with no late flag, adds nothing.
- R2: For code c, let v = (c − OFFSET_Q)·213. This is log2 of the threshold rate in Q8. Let I = floor(v/256) and F = v − 256·I. The interval length is 2^N bits with N = clamp(3 − I, MIN_LOG2, MAX_LOG2). The limit count is 8 + floor(F/32).
- R3: The error count saturates at 2^ERR_W − 1 and never wraps.
- R4: At the end of an interval whose error count is greater than the limit, `alarm_n` goes to 0 on the clock edge that ends the interval. A count equal to the limit does not raise the alarm.
- R5: A raised alarm returns to 1 only at the end of an interval whose count is at most floor(limit/2). A count above that and at most the limit leaves the alarm unchanged.
- R6: `alarm_n` changes only on the clock edge that ends an interval. The error count restarts from zero for the next interval.
- R7: With a threshold code of 0 the alarm stays at 1, whatever errors arrive.
- R8: Synchronous active-low reset clears the counters and forces `alarm_n` to 1. The threshold code is captured during reset and again at every interval end. A captured code governs the whole following interval, and changes in between have no effect until then.
- R9: The first interval starts with the first clock edge after reset is released. Every interval is exactly 2^N clock cycles long, one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one bit per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| edge_seen | input | 1 | A data transition occurred in this bit |
| edge_late | input | 1 | The transition fell outside the timing window |
| thr_code | input | CODE_W | Logarithmic threshold code, 0 disables |
| alarm_n | output | 1 | Error-rate alarm, 0 while raised |

## Verification
The bench builds the block with OFFSET_Q = 8, ERR_W = 5, MIN_LOG2 = 3, MAX_LOG2 = 12 and CODE_W = 6. With these values, codes 1 to 4 give intervals of 128 to 512 bits, and code 12 hits the lower clamp at 8 bits. The boundaries at the limit and at half the limit can then be exercised in a few hundred cycles. The 5-bit counter saturates inside a single 128-bit interval that is all errors. A wrapping counter would read zero there and leave the alarm high, so the saturation case gives a visible difference at the port.

// File: rtl/ewbm_pkg.sv
package ewbm_pkg;

  typedef enum logic {
    ALARM_CLEAR  = 1'b0,
    ALARM_RAISED = 1'b1
  } alarm_state_e;

  // log2(10)/4 in Q8: one quarter decade of rate expressed in binary octaves
  localparam int QDEC_TO_LOG2_Q8 = 213;
  // the limit count always lands in [LIMIT_BASE, 2*LIMIT_BASE)
  localparam int LIMIT_BASE_LOG2 = 3;
  localparam int LIMIT_BASE      = 8;
  localparam int LIMIT_W         = 4;

  // log2 of the threshold rate in Q8; code steps are quarter decades
  function automatic int rate_log2_q8(input int code, input int offset_q);
    return (code - offset_q) * QDEC_TO_LOG2_Q8;
  endfunction

  // interval length exponent: 2^n * rate lands in [8, 16)
  function automatic int interval_log2(input int code, input int offset_q,
                                       input int min_log2, input int max_log2);
    int n;
    n = LIMIT_BASE_LOG2 - (rate_log2_q8(code, offset_q) >>> 8);
    if (n < min_log2) n = min_log2;
    if (n > max_log2) n = max_log2;
    return n;
  endfunction

  // limit = 8 * 2^(frac), with 2^x approximated by 1 + x, in whole counts
  function automatic int limit_count(input int code, input int offset_q);
    int frac;
    frac = rate_log2_q8(code, offset_q) & 255;
    return LIMIT_BASE + (frac >> 5);
  endfunction

  function automatic logic over_limit(input int cnt, input int lim);
    return cnt > lim;
  endfunction

  function automatic logic within_release(input int cnt, input int lim);
    return cnt <= (lim >> 1);
  endfunction

endpackage

// File: rtl/ewbm_thr_map.sv
module ewbm_thr_map #(
  parameter int CODE_W   = 6,
  parameter int OFFSET_Q = 52,
  parameter int MIN_LOG2 = 3,
  parameter int MAX_LOG2 = 40,
  parameter int LOG2_W   = 6
) (
  input  logic [CODE_W-1:0]              code,
  output logic [LOG2_W-1:0]              ilog2,
  output logic [ewbm_pkg::LIMIT_W-1:0]   limit,
  output logic                           disabled
);
  import ewbm_pkg::*;

  int code_i;

  always_comb begin
    code_i   = int'(code);
    ilog2    = LOG2_W'(interval_log2(code_i, OFFSET_Q, MIN_LOG2, MAX_LOG2));
    limit    = LIMIT_W'(limit_count(code_i, OFFSET_Q));
    disabled = (code == '0);
  end

endmodule

// File: rtl/ewbm_interval_timer.sv
module ewbm_interval_timer #(
  parameter int MAX_LOG2 = 40,
  parameter int LOG2_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG2_W-1:0] ilog2,
  output logic              term
);
  logic [MAX_LOG2-1:0] bit_cnt_q;
  logic [MAX_LOG2-1:0] last_idx;

  // last bit index of an interval of 2^ilog2 bits: ilog2 low ones
  for (genvar i = 0; i < MAX_LOG2; i++) begin : g_last
    assign last_idx[i] = (LOG2_W'(i) < ilog2);
  end

  assign term = (bit_cnt_q == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n)    bit_cnt_q <= '0;
    else if (term) bit_cnt_q <= '0;
    else           bit_cnt_q <= bit_cnt_q + 1'b1;
  end

endmodule

// File: rtl/ewbm_err_counter.sv
module ewbm_err_counter #(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             term,
  output logic [ERR_W-1:0] err_cnt,
  output logic [ERR_W-1:0] count_final
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  logic [ERR_W-1:0] err_cnt_q;

  // total including the current bit, held at the top instead of wrapping
  assign count_final = (hit && (err_cnt_q != CNT_MAX)) ? err_cnt_q + 1'b1 : err_cnt_q;
  assign err_cnt     = err_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    err_cnt_q <= '0;
    else if (term) err_cnt_q <= '0;
    else           err_cnt_q <= count_final;
  end

endmodule

// File: rtl/ewbm_alarm_ctrl.sv
module ewbm_alarm_ctrl #(
  parameter int ERR_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         term,
  input  logic [ERR_W-1:0]             count_final,
  input  logic [ewbm_pkg::LIMIT_W-1:0] limit,
  input  logic                         disabled,
  output logic                         alarm_n
);
  import ewbm_pkg::*;

  alarm_state_e state_q, state_d;
  logic         above, releasable;

  always_comb begin
    above      = over_limit(int'(count_final), int'(limit));
    releasable = within_release(int'(count_final), int'(limit));
    state_d    = state_q;
    if (term) begin
      if (disabled)        state_d = ALARM_CLEAR;
      else if (above)      state_d = ALARM_RAISED;
      else if (releasable) state_d = ALARM_CLEAR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ALARM_CLEAR;
    else        state_q <= state_d;
  end

  assign alarm_n = (state_q != ALARM_RAISED);

endmodule

// File: rtl/edge_window_ber_monitor.sv
module edge_window_ber_monitor #(
  parameter int CODE_W   = 6,
  parameter int OFFSET_Q = 52,
  parameter int ERR_W    = 16,
  parameter int MIN_LOG2 = 3,
  parameter int MAX_LOG2 = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_seen,
  input  logic              edge_late,
  input  logic [CODE_W-1:0] thr_code,
  output logic              alarm_n
);
  localparam int LOG2_W = $clog2(MAX_LOG2 + 1);
  localparam int LIM_W  = ewbm_pkg::LIMIT_W;

  logic [LOG2_W-1:0] map_ilog2, cfg_ilog2;
  logic [LIM_W-1:0]  map_limit, cfg_limit;
  logic              map_disabled, cfg_disabled;
  logic              hit, term;
  logic [ERR_W-1:0]  err_cnt, count_final;

  assign hit = edge_seen & edge_late;

  ewbm_thr_map #(
    .CODE_W  (CODE_W),
    .OFFSET_Q(OFFSET_Q),
    .MIN_LOG2(MIN_LOG2),
    .MAX_LOG2(MAX_LOG2),
    .LOG2_W  (LOG2_W)
  ) u_map (
    .code    (thr_code),
    .ilog2   (map_ilog2),
    .limit   (map_limit),
    .disabled(map_disabled)
  );

  // threshold snapshot: taken in reset and at each interval end
  always_ff @(posedge clk) begin
    if (!rst_n || term) begin
      cfg_ilog2    <= map_ilog2;
      cfg_limit    <= map_limit;
      cfg_disabled <= map_disabled;
    end
  end

  ewbm_interval_timer #(
    .MAX_LOG2(MAX_LOG2),
    .LOG2_W  (LOG2_W)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .ilog2(cfg_ilog2),
    .term (term)
  );

  ewbm_err_counter #(
    .ERR_W(ERR_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .term       (term),
    .err_cnt    (err_cnt),
    .count_final(count_final)
  );

  ewbm_alarm_ctrl #(
    .ERR_W(ERR_W)
  ) u_alarm (
    .clk        (clk),
    .rst_n      (rst_n),
    .term       (term),
    .count_final(count_final),
    .limit      (cfg_limit),
    .disabled   (cfg_disabled),
    .alarm_n    (alarm_n)
  );

endmodule

// File: rtl/ewbm_checker.sv
module ewbm_checker #(
  parameter int ERR_W = 16,
  parameter int LIM_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edge_seen,
  input logic             edge_late,
  input logic             alarm_n,
  input logic             term,
  input logic [ERR_W-1:0] err_cnt,
  input logic [ERR_W-1:0] count_final,
  input logic [LIM_W-1:0] cfg_limit,
  input logic             cfg_disabled
);
  logic [ERR_W-1:0] lim_x;
  assign lim_x = ERR_W'(cfg_limit);

  p_reset_idle_r8: assert property (@(posedge clk) !rst_n |=> alarm_n);

  p_stable_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> $stable(alarm_n));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (err_cnt == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_cnt == '1) && !term) |=> (err_cnt == '1));

  p_no_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!term && !(edge_seen && edge_late)) |=> $stable(err_cnt));

  p_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !cfg_disabled && (count_final > lim_x)) |=> !alarm_n);

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (term && (count_final <= (lim_x >> 1))) |=> alarm_n);

  p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (term && cfg_disabled) |=> alarm_n);

endmodule

bind edge_window_ber_monitor ewbm_checker #(
  .ERR_W(ERR_W),
  .LIM_W(LIM_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .edge_seen   (edge_seen),
  .edge_late   (edge_late),
  .alarm_n     (alarm_n),
  .term        (term),
  .err_cnt     (err_cnt),
  .count_final (count_final),
  .cfg_limit   (cfg_limit),
  .cfg_disabled(cfg_disabled)
);

// File: tb/edge_window_ber_monitor_tb.sv
module edge_window_ber_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 6;
  localparam int OFFSET_Q   = 8;
  localparam int ERR_W      = 5;
  localparam int MIN_LOG2   = 3;
  localparam int MAX_LOG2   = 12;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              edge_seen = 1'b0;
  logic              edge_late = 1'b0;
  logic [CODE_W-1:0] thr_code = '0;
  logic              alarm_n;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_window_ber_monitor #(
    .CODE_W  (CODE_W),
    .OFFSET_Q(OFFSET_Q),
    .ERR_W   (ERR_W),
    .MIN_LOG2(MIN_LOG2),
    .MAX_LOG2(MAX_LOG2)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_seen(edge_seen),
    .edge_late(edge_late),
    .thr_code (thr_code),
    .alarm_n  (alarm_n)
  );

  // ---- reference model of the threshold mapping, from R2 ----
  function automatic int ref_floor256(input int v);
    int k = 0;
    if (v >= 0) while ((k + 1) * 256 <= v) k++;
    else        while (k * 256 > v) k--;
    return k;
  endfunction

  function automatic int ref_bits(input int code);
    int v = (code - OFFSET_Q) * 213;
    int n = 3 - ref_floor256(v);
    if (n < MIN_LOG2) n = MIN_LOG2;
    if (n > MAX_LOG2) n = MAX_LOG2;
    return 1 << n;
  endfunction

  function automatic int ref_limit(input int code);
    int v = (code - OFFSET_Q) * 213;
    return 8 + (v - 256 * ref_floor256(v)) / 32;
  endfunction

  // ---- helpers ----
  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  task automatic chk_alarm(input string req, input logic exp);
    n_checks++;
    if (alarm_n !== exp) begin
      n_fails++;
      $display("FAIL %s: alarm_n=%0b expected %0b at %0t", req, alarm_n, exp, $time);
    end
  endtask

  task automatic apply_reset(input int code);
    rst_n     = 1'b0;
    edge_seen = 1'b0;
    edge_late = 1'b0;
    thr_code  = CODE_W'(code);
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b1;
  endtask

  // n bits; the first n_err are real errors, the rest are decoys that
  // must not count (R1): transition without late flag, late flag alone
  task automatic drive_bits(input int n, input int n_err);
    for (int i = 0; i < n; i++) begin
      if (i < n_err) begin
        edge_seen = 1'b1;
        edge_late = 1'b1;
      end else begin
        edge_seen = (i % 2 == 0);
        edge_late = (i % 2 == 1);
      end
      @(posedge clk);
      #(CLK_PERIOD/4);
    end
    edge_seen = 1'b0;
    edge_late = 1'b0;
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    apply_reset(4);
    chk_alarm("R8 reset state", 1'b1);
  endtask

  task automatic t_raise_and_hysteresis();
    int lim  = ref_limit(4);
    int bits = ref_bits(4);
    apply_reset(4);
    drive_bits(bits, lim);
    chk_alarm("R4 count equal to limit keeps alarm off", 1'b1);
    drive_bits(bits - 1, lim + 1);
    chk_alarm("R9 no decision before interval end", 1'b1);
    drive_bits(1, 0);
    chk_alarm("R4 count above limit raises alarm", 1'b0);
    drive_bits(bits / 2, (lim / 2) + 1);
    chk_alarm("R6 alarm held mid-interval", 1'b0);
    drive_bits(bits / 2, 0);
    chk_alarm("R5 count above half limit holds alarm", 1'b0);
    drive_bits(bits - 1, lim / 2);
    chk_alarm("R6 release waits for interval end", 1'b0);
    drive_bits(1, 0);
    chk_alarm("R5 count at half limit releases alarm", 1'b1);
  endtask

  task automatic t_decoys_ignored();
    int bits = ref_bits(4);
    apply_reset(4);
    drive_bits(bits, 0);
    chk_alarm("R1 lone transitions and lone late flags not counted", 1'b1);
    drive_bits(bits, ref_limit(4) + 1);
    chk_alarm("R1 real errors among decoys counted", 1'b0);
  endtask

  task automatic t_saturation();
    int bits = ref_bits(4);
    apply_reset(4);
    drive_bits(bits, bits);
    chk_alarm("R3 saturated count still above limit", 1'b0);
  endtask

  task automatic t_disabled();
    int bits = ref_bits(0);
    apply_reset(0);
    drive_bits(bits, bits);
    chk_alarm("R7 code zero keeps alarm off", 1'b1);
    drive_bits(bits, bits);
    chk_alarm("R7 code zero second interval", 1'b1);
  endtask

  task automatic t_mapping(input int code);
    int lim  = ref_limit(code);
    int bits = ref_bits(code);
    apply_reset(code);
    drive_bits(bits, lim);
    chk_alarm("R2 mapped limit not exceeded", 1'b1);
    drive_bits(bits, lim + 1);
    chk_alarm("R2 mapped limit exceeded", 1'b0);
  endtask

  task automatic t_clamp();
    int bits = ref_bits(12);
    apply_reset(12);
    drive_bits(bits, bits);
    chk_alarm("R2 clamped interval cannot exceed its limit", 1'b1);
  endtask

  task automatic t_snapshot();
    int bits4 = ref_bits(4);
    int bits2 = ref_bits(2);
    apply_reset(4);
    drive_bits(10, 0);
    thr_code = CODE_W'(2);
    drive_bits(bits4 - 10, ref_limit(4) + 1);
    chk_alarm("R8 captured code governs current interval", 1'b0);
    drive_bits(bits2 - 1, 0);
    chk_alarm("R8 new code sets next interval length", 1'b0);
    drive_bits(1, 0);
    chk_alarm("R8 new interval ends on new length", 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_raise_and_hysteresis();
    t_decoys_ignored();
    t_saturation();
    t_disabled();
    t_mapping(1);
    t_mapping(2);
    t_clamp();
    t_snapshot();
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule